// File: doc/BRIEF.md
# Host Write Plane Steering Unit

This block takes byte writes from a host port and spreads them across a display memory split into four planes. For each write it works out which planes accept the byte and which location inside those planes receives it. Three schemes are supported. In the masked linear scheme, one host address maps to the same location in every plane that is enabled. In the chained scheme, the two lowest address bits pick exactly one plane. In the paired scheme, the parity of the address picks either the even planes or the odd planes.

A four-bit plane mask is applied after the scheme's choice, and a write strobe gates everything. The chosen enables and the rewritten plane address are registered once and then drive four small plane memories inside the block. A combinational probe port reads the same location from all four planes. The surrounding system, or a testbench, uses that port to see what landed where.

Top module: `plane_write_steer`

## Requirements
- R1: Plane n (n = 0..3) is written only when bit n of `planeMask` is 1; a plane whose mask bit is 0 keeps its contents in every scheme.
- R2: With `chainFour` = 1, only one plane can be written: host address bits [1:0] = 0, 1, 2, 3 select plane 0, 1, 2, 3 respectively.
- R3: With `chainFour` = 0 and `oddEvenDis` = 0, an even host address enables planes 0 and 2 (`planeWe` = 4'b0101) and an odd one enables planes 1 and 3 (4'b1010), before masking.
- R4: With `chainFour` = 0 and `oddEvenDis` = 1, every plane whose mask bit is set is written, and `planeAddr` equals the host address unchanged.
- R5: In the chained scheme, `planeAddr` equals the host address shifted right by two.
- R6: In the paired scheme, `planeAddr` equals the host address with bit 0 forced to 0.
- R7: When `chainFour` = 1 the chained scheme applies whatever the value of `oddEvenDis`.
- R8: When `hostWrStb` is 0, `planeWe` is 4'b0000 on the next cycle and no plane changes, whatever the mask.
- R9: `planeWe` and `planeAddr` reflect the write presented at a rising edge from just after that edge, and the byte is stored in the plane memory at the following edge. While `rstN` is low, `planeWe` is 0.
- R10: `probeData` bits [8n+7:8n] hold the byte stored in plane n at `probeAddr`, read combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the steering register |
| hostAddr | input | 8 | Host byte address |
| hostData | input | 8 | Host write byte |
| hostWrStb | input | 1 | Host write strobe, one write per high cycle |
| planeMask | input | 4 | Per-plane write enable mask, bit n for plane n |
| chainFour | input | 1 | Selects the chained scheme (low address bits pick the plane) |
| oddEvenDis | input | 1 | 0 selects the paired scheme when not chained; 1 selects linear |
| planeWe | output | 4 | Registered per-plane write enables |
| planeAddr | output | 8 | Registered plane-local address shared by all planes |
| probeAddr | input | 8 | Read address for the probe port |
| probeData | output | 32 | Bytes of planes 3..0 at probeAddr |

## Verification
A wrong scheme decode shows up on `planeWe` one cycle after the write is presented. A chained write that lights two planes, or a paired write that lands on the wrong parity, can be seen right away, before anything is stored. A wrong address rewrite can also be seen on `planeAddr` in that same cycle. It appears in memory contents only one edge later, as a byte at the wrong location that the probe exposes. Writes are laid over earlier writes with distinct data, so a stray enable shows up as a clobbered neighbour, not as a silent duplicate.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int NUM_PLANES = 4;
  localparam int SEL_W = $clog2(NUM_PLANES);

  // Address rewrite scheme chosen for one write
  typedef enum logic [1:0] {
    MODE_LINEAR  = 2'd0,
    MODE_PAIRED  = 2'd1,
    MODE_CHAINED = 2'd2
  } addrMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_PLANES-1:0] laneWe;
    addrMode_t             mode;
  } steerStrobes_t;

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
(
  input  logic [SEL_W-1:0]      addrLow,
  input  logic                  hostWrStb,
  input  logic [NUM_PLANES-1:0] planeMask,
  input  logic                  chainFour,
  input  logic                  oddEvenDis,
  output steerStrobes_t         strobes
);

  addrMode_t             mode;
  logic [NUM_PLANES-1:0] modeHit;

  // Chaining outranks the paired scheme
  always_comb begin
    if (chainFour)        mode = MODE_CHAINED;
    else if (!oddEvenDis) mode = MODE_PAIRED;
    else                  mode = MODE_LINEAR;
  end

  // Per-plane selection by scheme
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_hit
    localparam logic [SEL_W-1:0] PIDX = SEL_W'(p);
    always_comb begin
      unique case (mode)
        MODE_CHAINED: modeHit[p] = (addrLow == PIDX);
        MODE_PAIRED:  modeHit[p] = (addrLow[0] == PIDX[0]);
        default:      modeHit[p] = 1'b1;
      endcase
    end
  end

  always_comb begin
    strobes.mode   = mode;
    strobes.laneWe = modeHit & planeMask & {NUM_PLANES{hostWrStb}};
  end

endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  steerStrobes_t                strobes,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic [DATA_W-1:0]            hostData,
  output logic [NUM_PLANES-1:0]        planeWe,
  output logic [ADDR_W-1:0]            planeAddr,
  input  logic [ADDR_W-1:0]            probeAddr,
  output logic [NUM_PLANES*DATA_W-1:0] probeData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] nextAddr;
  logic [DATA_W-1:0] wrData;

  always_comb begin
    unique case (strobes.mode)
      MODE_CHAINED: nextAddr = hostAddr >> SEL_W;
      MODE_PAIRED:  nextAddr = {hostAddr[ADDR_W-1:1], 1'b0};
      default:      nextAddr = hostAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      planeWe   <= '0;
      planeAddr <= '0;
      wrData    <= '0;
    end else begin
      planeWe   <= strobes.laneWe;
      planeAddr <= nextAddr;
      wrData    <= hostData;
    end
  end

  for (genvar g = 0; g < NUM_PLANES; g++) begin : g_plane
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (planeWe[g]) mem[planeAddr] <= wrData;
    end
    assign probeData[g*DATA_W +: DATA_W] = mem[probeAddr];
  end

  // R9: the registered address follows the rewrite chosen one edge earlier
  assert_addr_linear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mode == MODE_LINEAR) |=> planeAddr == $past(hostAddr));

endmodule

// File: rtl/plane_write_steer.sv
module plane_write_steer
  import steer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic [DATA_W-1:0]            hostData,
  input  logic                         hostWrStb,
  input  logic [NUM_PLANES-1:0]        planeMask,
  input  logic                         chainFour,
  input  logic                         oddEvenDis,
  output logic [NUM_PLANES-1:0]        planeWe,
  output logic [ADDR_W-1:0]            planeAddr,
  input  logic [ADDR_W-1:0]            probeAddr,
  output logic [NUM_PLANES*DATA_W-1:0] probeData
);

  steerStrobes_t strobes;

  steer_ctrl u_ctrl (
    .addrLow    (hostAddr[SEL_W-1:0]),
    .hostWrStb  (hostWrStb),
    .planeMask  (planeMask),
    .chainFour  (chainFour),
    .oddEvenDis (oddEvenDis),
    .strobes    (strobes)
  );

  steer_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostAddr  (hostAddr),
    .hostData  (hostData),
    .planeWe   (planeWe),
    .planeAddr (planeAddr),
    .probeAddr (probeAddr),
    .probeData (probeData)
  );

  assert_mask_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (planeWe & ~$past(planeMask)) == '0);

  assert_chain_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    chainFour |=> $onehot0(planeWe));

  assert_paired_parity_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!chainFour && !oddEvenDis && hostAddr[0]) |=> (planeWe & 4'b0101) == '0);

  assert_chain_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    chainFour |=> planeAddr == ($past(hostAddr) >> SEL_W));

  assert_paired_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!chainFour && !oddEvenDis) |=> planeAddr[0] == 1'b0);

  assert_no_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrStb |=> planeWe == '0);

endmodule

// File: tb/plane_write_steer_tb.sv
module plane_write_steer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [7:0]  hostData = '0;
  logic        hostWrStb = 1'b0;
  logic [3:0]  planeMask = '0;
  logic        chainFour = 1'b0;
  logic        oddEvenDis = 1'b1;
  logic [3:0]  planeWe;
  logic [7:0]  planeAddr;
  logic [7:0]  probeAddr = '0;
  logic [31:0] probeData;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  plane_write_steer u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostData(hostData),
    .hostWrStb(hostWrStb), .planeMask(planeMask), .chainFour(chainFour),
    .oddEvenDis(oddEvenDis), .planeWe(planeWe), .planeAddr(planeAddr),
    .probeAddr(probeAddr), .probeData(probeData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expWe(input logic [7:0] a, input logic [3:0] m,
                                       input logic ch, input logic oe, input logic stb);
    logic [3:0] sel;
    if (ch)       sel = 4'b0001 << a[1:0];
    else if (!oe) sel = a[0] ? 4'b1010 : 4'b0101;
    else          sel = 4'b1111;
    return stb ? (sel & m) : 4'b0000;
  endfunction

  function automatic logic [7:0] expAddr(input logic [7:0] a, input logic ch, input logic oe);
    if (ch)       return a >> 2;
    else if (!oe) return {a[7:1], 1'b0};
    else          return a;
  endfunction

  // One write: check steering one edge later, then let it land
  task automatic doWrite(input string req, input logic [7:0] a, input logic [7:0] d,
                         input logic [3:0] m, input logic ch, input logic oe, input logic stb);
    @(negedge clk);
    hostAddr = a; hostData = d; planeMask = m;
    chainFour = ch; oddEvenDis = oe; hostWrStb = stb;
    @(posedge clk); #1;
    check({req, " planeWe"}, {28'd0, planeWe}, {28'd0, expWe(a, m, ch, oe, stb)});
    check({req, " planeAddr"}, {24'd0, planeAddr}, {24'd0, expAddr(a, ch, oe)});
    @(negedge clk);
    hostWrStb = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic probe(input string req, input logic [7:0] a, input int plane,
                       input logic [7:0] exp);
    probeAddr = a; #1;
    check(req, {24'd0, probeData[plane*8 +: 8]}, {24'd0, exp});
  endtask

  task automatic testReset();
    check("R9 reset planeWe", {28'd0, planeWe}, 32'd0);
  endtask

  task automatic testLinear();
    doWrite("R4 linear", 8'h10, 8'hA5, 4'hF, 1'b0, 1'b1, 1'b1);
    for (int p = 0; p < 4; p++) probe("R10 R4 linear data", 8'h10, p, 8'hA5);
    check("R9 idle after write", {28'd0, planeWe}, 32'd0);
  endtask

  task automatic testMask();
    doWrite("R1 mask", 8'h10, 8'h3C, 4'b0101, 1'b0, 1'b1, 1'b1);
    probe("R1 plane0 written", 8'h10, 0, 8'h3C);
    probe("R1 plane1 kept", 8'h10, 1, 8'hA5);
    probe("R1 plane2 written", 8'h10, 2, 8'h3C);
    probe("R1 plane3 kept", 8'h10, 3, 8'hA5);
  endtask

  task automatic testChain();
    for (int p = 0; p < 4; p++)
      doWrite("R2 R5 chain", 8'h40 + 8'(p), 8'h80 + 8'(p), 4'hF, 1'b1, 1'b1, 1'b1);
    for (int p = 0; p < 4; p++) probe("R2 R5 chain data", 8'h10, p, 8'h80 + 8'(p));
    doWrite("R1 R2 chain masked", 8'h42, 8'hEE, 4'b1011, 1'b1, 1'b1, 1'b1);
    probe("R1 chain masked plane kept", 8'h10, 2, 8'h82);
  endtask

  task automatic testPaired();
    doWrite("R3 R6 paired odd", 8'h21, 8'h5A, 4'hF, 1'b0, 1'b0, 1'b1);
    doWrite("R3 R6 paired even", 8'h20, 8'h6B, 4'hF, 1'b0, 1'b0, 1'b1);
    probe("R3 plane0 even", 8'h20, 0, 8'h6B);
    probe("R3 plane1 odd", 8'h20, 1, 8'h5A);
    probe("R3 plane2 even", 8'h20, 2, 8'h6B);
    probe("R3 plane3 odd", 8'h20, 3, 8'h5A);
  endtask

  task automatic testPriority();
    doWrite("R7 chain over paired", 8'h05, 8'h11, 4'hF, 1'b1, 1'b0, 1'b1);
    probe("R7 chain data", 8'h01, 1, 8'h11);
  endtask

  task automatic testNoStrobe();
    doWrite("R8 no strobe", 8'h10, 8'hFF, 4'hF, 1'b0, 1'b1, 1'b0);
    probe("R8 plane0 kept", 8'h10, 0, 8'h80);
    probe("R8 plane3 kept", 8'h10, 3, 8'h83);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 testReset();
    @(negedge clk) rstN = 1'b1;
    testLinear();
    testMask();
    testChain();
    testPaired();
    testPriority();
    testNoStrobe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL R9 watchdog expired: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule